// File: doc/BRIEF.md
# Serial Flash Operation Sequencer

This block sits above a byte-oriented serial-flash command engine and turns one high-level request into the full chain of engine transactions that a flash operation needs. The supported operations are status read, identification read, status write, write disable, sector erase, chip erase, single-byte program and 32-bit word program. For each operation the sequencer does the following:

- It sends a write-enable command ahead of any erase or program command.
- It sends the command itself, with the address and data bytes laid out in the order the flash expects.
- It reads the flash status register repeatedly until the flash reports that it is no longer busy.

A 32-bit word program is sent in one of two ways, selected by a plain control pin. It can go out as a single seven-byte command. It can also go out as four separate one-byte programs. In the second form each byte gets its own write-enable and its own busy poll, and the address advances by one for each byte.

Requests arrive on a valid/ready channel. `req_ready` is high only while the sequencer is idle, so a requester that holds `req_valid` high simply waits. A transfer takes place on any clock edge where both are high. Commands leave on a second valid/ready channel towards the engine. While `eng_req_valid` is high and `eng_req_ready` is low, every command field holds steady. Only one command is outstanding at a time. The engine reports completion with a one-cycle `eng_done` pulse, and `eng_rx_data` is valid in that cycle. Completion of an operation is a one-cycle `done` pulse with no back-pressure. In that cycle `rsp_data` and `err` are valid, and both hold their values until the next request is accepted.

Top module: `flash_op_seq`

## Requirements
- R1: A request is accepted only while the sequencer is idle. Once it is accepted, `req_ready` stays low until the operation has finished, and requests presented in the meantime are neither taken nor acted on. Operation codes on `req_op` are:
  - 0: status read
  - 1: ID read
  - 2: status write
  - 3: sector erase
  - 4: chip erase
  - 5: byte program
  - 6: word program
  - 7: write disable
- R2: Sector erase, chip erase, byte program and word program are each preceded by a write-enable command: opcode 0x06, no transmit bytes, no receive bytes.
- R3: A status read uses opcode 0x05 with one zero transmit byte and one receive byte. After every erase, program or status write, such reads repeat until bit 0 of the returned status (busy) is 0. A status-read request returns the status byte in `rsp_data[7:0]`.
- R4: A status write sends 0x50 with no data, then 0x01 with one transmit byte equal to `req_data[7:0]`, then polls until the flash is ready, then performs one more status read. That final status byte is returned in `rsp_data[7:0]`.
- R5: Sector erase sends 0x20 with three transmit bytes, the address most significant byte first. Chip erase sends 0xC7 with no transmit bytes.
- R6: Byte program sends 0x02 with four transmit bytes: the three address bytes, most significant first, then `req_data[7:0]`.
- R7: With `split_word` low, a word program sends 0x02 with seven transmit bytes: the three address bytes, most significant first, then the four data bytes, least significant first.
- R8: With `split_word` high, a word program performs four byte programs. Byte i (i = 0..3) has its own write-enable and busy poll, uses address `req_addr + i` (modulo 2^24) and data byte `req_data[8i+7:8i]`.
- R9: ID read sends 0x90 with three zero transmit bytes and two receive bytes. The first received byte (manufacturer) is returned in `rsp_data[7:0]` and the second (device) in `rsp_data[15:8]`.
- R10: Write disable sends 0x04 with no transmit or receive bytes and performs no polling.
- R11: Every operation ends with exactly one single-cycle `done` pulse. `rsp_data` is 0 for operations that return no data.
- R12: If POLL_LIMIT consecutive status reads within one poll all report busy, the operation is abandoned. `err` is then raised together with `done`, and no further command of that operation is sent. `err` is 0 after a successful operation.
- R13: Transmit byte k occupies `eng_tx_data[8k+7:8k]`, with byte 0 sent first, and unused bytes are 0. Received byte k arrives on `eng_rx_data[8k+7:8k]`. While `eng_req_valid` is high and `eng_req_ready` is low, the opcode, counts and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | 24 | Flash byte address |
| req_data | input | 32 | Program data or new status byte |
| split_word | input | 1 | Word program as four byte programs when high |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Busy poll timed out |
| rsp_data | output | 16 | Read result |
| eng_req_valid | output | 1 | Engine command valid |
| eng_req_ready | input | 1 | Engine takes the command |
| eng_opcode | output | 8 | Command opcode |
| eng_tx_cnt | output | 3 | Number of transmit bytes after the opcode |
| eng_rx_cnt | output | 2 | Number of receive bytes |
| eng_tx_data | output | 56 | Transmit bytes, byte 0 in the low bits |
| eng_done | input | 1 | Engine command complete pulse |
| eng_rx_data | input | 16 | Received bytes, byte 0 in the low bits |

## Verification
The bench builds the sequencer with POLL_LIMIT set to 4. This lets a flash model that stays busy for 0 to 4 status reads land on both sides of the timeout boundary: three busy reads still succeed, and four abandon the operation. It sweeps every operation code against both `split_word` settings and every busy depth, and compares the complete engine transaction list, including the byte packing, against a list computed arithmetically from the requirements. Each run uses a different address and data pattern, and some of them carry across address bytes when the split program increments the address. The engine model stalls each command for one cycle before taking it, which exercises the hold rule on the command channel.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    OP_RDSR   = 3'd0,
    OP_RDID   = 3'd1,
    OP_WRSR   = 3'd2,
    OP_SERASE = 3'd3,
    OP_CERASE = 3'd4,
    OP_PROG8  = 3'd5,
    OP_PROG32 = 3'd6,
    OP_WRDIS  = 3'd7
  } fop_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WREN, PH_EWSR, PH_CMD, PH_POLL, PH_FINAL, PH_DONE
  } phase_e;

  localparam int TX_BYTES = 7;
  localparam int RX_BYTES = 2;
  localparam int ADDR_W   = 24;
  localparam int DATA_W   = 32;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_EWSR  = 8'h50;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_RDID  = 8'h90;
  localparam logic [7:0] OPC_SE    = 8'h20;
  localparam logic [7:0] OPC_CE    = 8'hC7;
  localparam logic [7:0] OPC_PROG  = 8'h02;

endpackage

// File: rtl/fseq_frame.sv
module fseq_frame
  import fseq_pkg::*;
(
  input  phase_e                    phase,
  input  fop_e                      op,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         data,
  input  logic [1:0]                idx,
  input  logic                      split,
  output logic [7:0]                opcode,
  output logic [2:0]                tx_cnt,
  output logic [1:0]                rx_cnt,
  output logic [8*TX_BYTES-1:0]     tx_data
);

  logic [7:0]        b [TX_BYTES];
  logic [ADDR_W-1:0] badr;
  logic [DATA_W-1:0] dsh;

  assign badr = addr + ADDR_W'(idx);
  assign dsh  = data >> {idx, 3'b000};

  always_comb begin
    opcode = 8'h00;
    tx_cnt = 3'd0;
    rx_cnt = 2'd0;
    for (int k = 0; k < TX_BYTES; k++) b[k] = 8'h00;
    unique case (phase)
      PH_WREN: opcode = OPC_WREN;
      PH_EWSR: opcode = OPC_EWSR;
      PH_POLL, PH_FINAL: begin
        opcode = OPC_RDSR; tx_cnt = 3'd1; rx_cnt = 2'd1;
      end
      PH_CMD: begin
        unique case (op)
          OP_RDSR: begin opcode = OPC_RDSR; tx_cnt = 3'd1; rx_cnt = 2'd1; end
          OP_RDID: begin opcode = OPC_RDID; tx_cnt = 3'd3; rx_cnt = 2'd2; end
          OP_WRSR: begin opcode = OPC_WRSR; tx_cnt = 3'd1; b[0] = data[7:0]; end
          OP_WRDIS: opcode = OPC_WRDI;
          OP_CERASE: opcode = OPC_CE;
          OP_SERASE: begin
            opcode = OPC_SE; tx_cnt = 3'd3;
            b[0] = addr[23:16]; b[1] = addr[15:8]; b[2] = addr[7:0];
          end
          OP_PROG8, OP_PROG32: begin
            opcode = OPC_PROG;
            b[0] = badr[23:16]; b[1] = badr[15:8]; b[2] = badr[7:0];
            if (op == OP_PROG32 && !split) begin
              tx_cnt = 3'd7;
              b[3] = data[7:0];   b[4] = data[15:8];
              b[5] = data[23:16]; b[6] = data[31:24];
            end else begin
              tx_cnt = 3'd4;
              b[3] = dsh[7:0];
            end
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  for (genvar k = 0; k < TX_BYTES; k++) begin : g_pack
    assign tx_data[8*k +: 8] = b[k];
  end

endmodule

// File: rtl/fseq_poll.sv
module fseq_poll #(
  parameter int POLL_LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic busy_seen,
  output logic give_up
);

  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt;

  assign give_up = busy_seen && (cnt == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (busy_seen && !give_up) cnt <= cnt + 1'b1;
  end

  // R12: the busy-read count never runs past the limit
  p_poll_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(POLL_LIMIT));

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_data,
  input  logic                 split_word,
  output logic                 eng_req_valid,
  input  logic                 eng_req_ready,
  input  logic                 eng_done,
  input  logic [8*RX_BYTES-1:0] eng_rx_data,
  input  logic                 give_up,
  output logic                 poll_clr,
  output logic                 busy_seen,
  output phase_e               phase,
  output fop_e                 op_q,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [DATA_W-1:0]    data_q,
  output logic [1:0]           idx,
  output logic                 split_q,
  output logic                 done,
  output logic                 err,
  output logic [8*RX_BYTES-1:0] rsp_data
);

  logic waiting;
  logic accept;
  logic fin;
  fop_e req_op_e;

  assign req_op_e      = fop_e'(req_op);
  assign req_ready     = (phase == PH_IDLE);
  assign accept        = req_valid && req_ready;
  assign eng_req_valid = (phase != PH_IDLE) && (phase != PH_DONE) && !waiting;
  assign fin           = waiting && eng_done;
  assign busy_seen     = fin && (phase == PH_POLL) && eng_rx_data[0];
  assign poll_clr      = fin && (phase == PH_CMD);
  assign done          = (phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      op_q     <= OP_RDSR;
      addr_q   <= '0;
      data_q   <= '0;
      idx      <= '0;
      split_q  <= 1'b0;
      waiting  <= 1'b0;
      err      <= 1'b0;
      rsp_data <= '0;
    end else if (accept) begin
      op_q     <= req_op_e;
      addr_q   <= req_addr;
      data_q   <= req_data;
      split_q  <= split_word;
      idx      <= '0;
      err      <= 1'b0;
      rsp_data <= '0;
      unique case (req_op_e)
        OP_SERASE, OP_CERASE, OP_PROG8, OP_PROG32: phase <= PH_WREN;
        OP_WRSR: phase <= PH_EWSR;
        default: phase <= PH_CMD;
      endcase
    end else if (phase == PH_DONE) begin
      phase <= PH_IDLE;
    end else if (fin) begin
      waiting <= 1'b0;
      unique case (phase)
        PH_WREN, PH_EWSR: phase <= PH_CMD;
        PH_CMD: begin
          if (op_q == OP_RDSR) begin
            rsp_data <= {8'h00, eng_rx_data[7:0]};
            phase    <= PH_DONE;
          end else if (op_q == OP_RDID) begin
            rsp_data <= eng_rx_data;
            phase    <= PH_DONE;
          end else if (op_q == OP_WRDIS) begin
            phase <= PH_DONE;
          end else begin
            phase <= PH_POLL;
          end
        end
        PH_POLL: begin
          if (!eng_rx_data[0]) begin
            if (op_q == OP_WRSR) phase <= PH_FINAL;
            else if (op_q == OP_PROG32 && split_q && idx != 2'd3) begin
              idx   <= idx + 2'd1;
              phase <= PH_WREN;
            end else phase <= PH_DONE;
          end else if (give_up) begin
            err   <= 1'b1;
            phase <= PH_DONE;
          end
        end
        PH_FINAL: begin
          rsp_data <= {8'h00, eng_rx_data[7:0]};
          phase    <= PH_DONE;
        end
        default: ;
      endcase
    end else if (eng_req_valid && eng_req_ready) begin
      waiting <= 1'b1;
    end
  end

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: an accepted request closes the request channel
  p_accept_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R12: the error flag only rises together with completion
  p_err_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R13: after a command is taken, no new command appears before completion
  p_single_outstanding_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_valid && eng_req_ready) |=> !eng_req_valid);

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import fseq_pkg::*;
#(
  parameter int POLL_LIMIT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [23:0] req_addr,
  input  logic [31:0] req_data,
  input  logic        split_word,
  output logic        done,
  output logic        err,
  output logic [15:0] rsp_data,
  output logic        eng_req_valid,
  input  logic        eng_req_ready,
  output logic [7:0]  eng_opcode,
  output logic [2:0]  eng_tx_cnt,
  output logic [1:0]  eng_rx_cnt,
  output logic [55:0] eng_tx_data,
  input  logic        eng_done,
  input  logic [15:0] eng_rx_data
);

  phase_e            phase;
  fop_e              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        idx;
  logic              split_q;
  logic              give_up, poll_clr, busy_seen;

  fseq_ctrl u_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_data,
    .split_word, .eng_req_valid, .eng_req_ready, .eng_done, .eng_rx_data,
    .give_up, .poll_clr, .busy_seen, .phase, .op_q, .addr_q, .data_q,
    .idx, .split_q, .done, .err, .rsp_data
  );

  fseq_frame u_frame (
    .phase, .op(op_q), .addr(addr_q), .data(data_q), .idx, .split(split_q),
    .opcode(eng_opcode), .tx_cnt(eng_tx_cnt), .rx_cnt(eng_rx_cnt),
    .tx_data(eng_tx_data)
  );

  fseq_poll #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk, .rst_n, .clr(poll_clr), .busy_seen, .give_up
  );

  // R13: a stalled command keeps every field steady
  p_cmd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_valid && !eng_req_ready) |=> (eng_req_valid && $stable(eng_opcode)
      && $stable(eng_tx_cnt) && $stable(eng_rx_cnt) && $stable(eng_tx_data)));

endmodule

// File: tb/tb_flash_op_seq.sv
`timescale 1ns/1ps
module tb_flash_op_seq;

  localparam int LIM = 4;
  localparam logic [7:0] MFR = 8'hC2;
  localparam logic [7:0] DEV = 8'h17;
  localparam logic [7:0] STAT0 = 8'h5C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, split_word = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic req_ready, done, err, eng_req_valid;
  logic [15:0] rsp_data;
  logic eng_req_ready, eng_done;
  logic [15:0] eng_rx_data;
  logic [7:0] eng_opcode;
  logic [2:0] eng_tx_cnt;
  logic [1:0] eng_rx_cnt;
  logic [55:0] eng_tx_data;

  always #2.5 clk = ~clk;

  flash_op_seq #(.POLL_LIMIT(LIM)) dut (.*);

  int checks = 0, errs = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash + engine model
  logic [7:0]  r_opc [64];
  logic [55:0] r_tx  [64];
  logic [2:0]  r_txc [64];
  logic [1:0]  r_rxc [64];
  int rec_n = 0, hold_bad = 0, busy_cfg = 0, f_busy = 0;
  logic [7:0] f_status = STAT0;

  initial begin
    logic [7:0] s_opc; logic [55:0] s_tx; logic [2:0] s_txc; logic [1:0] s_rxc;
    logic [15:0] rx;
    eng_req_ready = 1'b0; eng_done = 1'b0; eng_rx_data = '0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (rst_n && eng_req_valid) begin
        s_opc = eng_opcode; s_tx = eng_tx_data; s_txc = eng_tx_cnt; s_rxc = eng_rx_cnt;
        @(negedge clk);
        if (!eng_req_valid || eng_opcode != s_opc || eng_tx_data != s_tx ||
            eng_tx_cnt != s_txc || eng_rx_cnt != s_rxc) hold_bad++;
        eng_req_ready = 1'b1;
        @(negedge clk);
        eng_req_ready = 1'b0;
        if (rec_n < 64) begin
          r_opc[rec_n] = s_opc; r_tx[rec_n] = s_tx; r_txc[rec_n] = s_txc; r_rxc[rec_n] = s_rxc;
        end
        rec_n++;
        rx = 16'h0000;
        case (s_opc)
          8'h05: if (f_busy > 0) begin rx = {8'h00, f_status | 8'h01}; f_busy--; end
                 else rx = {8'h00, f_status};
          8'h90: rx = {DEV, MFR};
          8'h01: begin f_status = s_tx[7:0] & 8'hFE; f_busy = busy_cfg; end
          8'h20, 8'hC7, 8'h02: f_busy = busy_cfg;
          default: ;
        endcase
        @(negedge clk);
        eng_rx_data = rx; eng_done = 1'b1;
      end
    end
  end

  // expected transaction list
  logic [7:0]  e_opc [64];
  logic [55:0] e_tx  [64];
  logic [2:0]  e_txc [64];
  logic [1:0]  e_rxc [64];
  int exp_n;
  bit exp_err;

  function automatic logic [23:0] adr3(input logic [23:0] a);
    return {a[7:0], a[15:8], a[23:16]};
  endfunction

  task automatic push(input logic [7:0] o, input logic [2:0] t, input logic [1:0] r, input logic [55:0] d);
    e_opc[exp_n] = o; e_txc[exp_n] = t; e_rxc[exp_n] = r; e_tx[exp_n] = d;
    exp_n++;
  endtask

  task automatic polls(input int busy);
    int n;
    n = (busy < LIM) ? busy + 1 : LIM;
    for (int i = 0; i < n; i++) push(8'h05, 3'd1, 2'd1, '0);
    if (busy >= LIM) exp_err = 1'b1;
  endtask

  function automatic string tag_of(input int op, input bit sp, input logic [7:0] o);
    if (o == 8'h06) return "R2";
    case (op)
      0: return "R3";
      1: return "R9";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6: return sp ? "R8" : "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(input int op, input bit sp, input int busy,
                        input logic [23:0] a, input logic [31:0] d);
    logic [15:0] exp_rsp;
    int wd, ready_bad;
    logic got_err; logic [15:0] got_rsp;
    string tg;
    exp_n = 0; exp_err = 1'b0; exp_rsp = '0;
    case (op)
      0: begin push(8'h05, 3'd1, 2'd1, '0); exp_rsp = {8'h00, STAT0}; end
      1: begin push(8'h90, 3'd3, 2'd2, '0); exp_rsp = {DEV, MFR}; end
      2: begin
        push(8'h50, 3'd0, 2'd0, '0);
        push(8'h01, 3'd1, 2'd0, {48'h0, d[7:0]});
        polls(busy);
        if (!exp_err) begin push(8'h05, 3'd1, 2'd1, '0); exp_rsp = {8'h00, d[7:0] & 8'hFE}; end
      end
      3: begin push(8'h06, 3'd0, 2'd0, '0); push(8'h20, 3'd3, 2'd0, {32'h0, adr3(a)}); polls(busy); end
      4: begin push(8'h06, 3'd0, 2'd0, '0); push(8'hC7, 3'd0, 2'd0, '0); polls(busy); end
      5: begin push(8'h06, 3'd0, 2'd0, '0); push(8'h02, 3'd4, 2'd0, {24'h0, d[7:0], adr3(a)}); polls(busy); end
      6: if (!sp) begin
           push(8'h06, 3'd0, 2'd0, '0);
           push(8'h02, 3'd7, 2'd0, {d[31:24], d[23:16], d[15:8], d[7:0], adr3(a)});
           polls(busy);
         end else begin
           for (int i = 0; i < 4; i++) begin
             if (!exp_err) begin
               logic [31:0] ds;
               ds = d >> (8 * i);
               push(8'h06, 3'd0, 2'd0, '0);
               push(8'h02, 3'd4, 2'd0, {24'h0, ds[7:0], adr3(a + 24'(i))});
               polls(busy);
             end
           end
         end
      default: push(8'h04, 3'd0, 2'd0, '0);
    endcase
    busy_cfg = busy; f_busy = 0; f_status = STAT0; rec_n = 0;
    hold_bad = 0; ready_bad = 0;
    tg = tag_of(op, sp, 8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_addr = a; req_data = d; split_word = sp;
    wd = 0;
    while (!req_ready && wd < 100) begin @(negedge clk); wd++; end
    @(negedge clk);
    // R1: keep presenting a different request while busy
    req_op = 3'd4; req_addr = ~a; split_word = ~sp;
    wd = 0;
    while (!done && wd < 3000) begin
      if (req_ready) ready_bad++;
      @(negedge clk); wd++;
    end
    chk(wd < 3000, "watchdog", 64'(wd), 64'd3000);
    got_err = err; got_rsp = rsp_data;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!done, "R11 done pulse width", 64'(done), 64'd0);
    chk(ready_bad == 0, "R1 ready while busy", 64'(ready_bad), 64'd0);
    chk(rec_n == exp_n, {tg, " command count"}, 64'(rec_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < rec_n && i < 64; i++) begin
      string t2;
      t2 = (i > 0 && e_opc[i] == 8'h05 && op != 0) ? "R3" : tag_of(op, sp, e_opc[i]);
      chk(r_opc[i] == e_opc[i] && r_txc[i] == e_txc[i] && r_rxc[i] == e_rxc[i] &&
          r_tx[i] == e_tx[i], {t2, " R13 command frame"},
          {r_opc[i], r_tx[i]}, {e_opc[i], e_tx[i]});
    end
    chk(got_err == exp_err, "R12 err", 64'(got_err), 64'(exp_err));
    chk(got_rsp == exp_rsp, {tg, " R11 rsp_data"}, 64'(got_rsp), 64'(exp_rsp));
    chk(hold_bad == 0, "R13 hold while stalled", 64'(hold_bad), 64'd0);
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !err && !eng_req_valid && rsp_data == 16'h0,
        "R1 R11 reset state", {req_ready, done, err, eng_req_valid}, 64'h8);
    t = 0;
    for (int op = 0; op < 8; op++)
      for (int sp = 0; sp < 2; sp++)
        for (int busy = 0; busy <= LIM; busy++) begin
          logic [23:0] a; logic [31:0] d;
          a = 24'h12FFFD + 24'(t) * 24'h010203;
          d = 32'hA1B2C3D4 ^ (32'(t) * 32'h01010101);
          run_op(op, sp[0], busy, a, d);
          t++;
        end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule